// File: doc/BRIEF.md
# Configurable UART frame engine

A full-duplex asynchronous serial engine that turns bytes into framed line bits and framed line bits back into bytes. A 7-bit line-control word sets the character length, parity, stop period and a forced break. A divisor word sets the bit rate. One bit lasts divisor + 2 system clocks, so the divisor is written as clk/baud − 2. The receiver marks every character it delivers with a parity-error, framing-error and break flag.

The transmit side takes bytes through a valid/ready input. `tx_ready` is high only while the transmitter is idle. A byte moves on a rising clock edge that sees both `tx_valid` and `tx_ready` high. The source may hold `tx_valid` high for as long as it likes: back-pressure simply lasts one whole frame.

The receive side cannot stall the serial line, so it has no ready input. `rx_valid` is a one-cycle strobe, and the consumer must take the character on that cycle. Line-control and divisor values are captured when a character starts, and a change applies from the next character. The break-control bit is the only exception: it acts at once.

Top module: `uart_frame_engine`

## Requirements
- R1: `line_ctrl[1:0]` sets the character length: 0 gives 5 data bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits go onto the line LSB first and are received LSB first. Unused upper bits of `rx_data` read 0.
- R2: `txd` idles high and `tx_ready` is high only while idle. A byte accepted at a clock edge drives the start bit (low) from the next cycle on, and `tx_ready` stays low until the last stop clock has passed.
- R3: Each start, data and parity bit lasts exactly `divisor` + 2 clock cycles. Valid divisor values are 9 to 65533.
- R4: `line_ctrl[3]` enables a parity bit after the data bits. With `line_ctrl[4]` set, the parity bit makes the count of ones in data plus parity even. With `line_ctrl[4]` clear, it makes that count odd.
- R5: With `line_ctrl[5]` and `line_ctrl[3]` both set, the parity bit is a constant: 0 when `line_ctrl[4]` is set and 1 when it is clear. The receiver checks against the same constant.
- R6: With `line_ctrl[2]` clear, the stop period is one bit time. With it set, the stop period is two bit times, or for 5-bit characters P + floor(P/2) clocks, where P is the bit time.
- R7: While `line_ctrl[6]` is high, `txd` is 0 from that same cycle on. A frame in progress keeps its timing and resumes on the line once the bit is cleared.
- R8: Line-control bits 5..0 and the divisor are captured at the start of a character. Changes made during a frame do not alter that frame.
- R9: A falling edge on `rxd` starts a frame only if the line is still low at the middle of the start bit. Otherwise the receiver goes back to hunting. Every bit is sampled once, near its middle.
- R10: For each character the receiver reports a parity mismatch on `rx_perr` and a low first stop bit on `rx_ferr`. It raises `rx_brk` when every sample of the frame, stop bit included, was low; in that case `rx_ferr` is also 1 and `rx_data` is 0.
- R11: After a character with a low stop bit, the receiver does not look for a new start bit until `rxd` has been high. A line held low therefore yields exactly one break character.
- R12: `rx_valid` is a single-cycle strobe. It rises between the middle and the end of the first stop bit, allowing for the input synchroniser delay, and it occurs once per accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_ctrl | input | 7 | Frame format: [1:0] length, [2] long stop, [3] parity on, [4] even, [5] stick, [6] break |
| divisor | input | 16 | Bit time minus 2, in clock cycles |
| tx_data | input | 8 | Byte to transmit (upper bits ignored for short characters) |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmitter idle and able to accept |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line (asynchronous) |
| rx_data | output | 8 | Received character, zero-extended |
| rx_valid | output | 1 | One-cycle strobe: received character and flags are valid |
| rx_perr | output | 1 | Parity mismatch on this character |
| rx_ferr | output | 1 | First stop bit sampled low |
| rx_brk | output | 1 | Whole frame sampled low |

## Verification
A wrong transmit state or bit counter shows on `txd` within one bit time, as a bit of the wrong level or of the wrong length. A stop period that is too short or too long shows up as `tx_ready` returning a cycle early or late. On the receive side, a counter or state error moves the `rx_valid` strobe out of its window or corrupts the character or its flags, and this is seen by the end of the same frame. A receiver that fails to wait for the line to go high shows as repeated break characters.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

  localparam int MAX_BITS = 8;
  localparam int LEN_W    = 4;

  typedef struct packed {
    logic       brk;
    logic       stick;
    logic       even;
    logic       par_en;
    logic       long_stop;
    logic [1:0] len;
  } line_cfg_t;

  typedef enum logic [2:0] {
    T_IDLE, T_START, T_DATA, T_PAR, T_STOP
  } tx_state_t;

  typedef enum logic [2:0] {
    R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_WAIT
  } rx_state_t;

  function automatic logic [LEN_W-1:0] char_bits(input logic [1:0] len);
    return LEN_W'(5) + {2'b00, len};
  endfunction

  function automatic logic par_bit(input logic [1:0] len, input logic even,
                                   input logic stick, input logic [MAX_BITS-1:0] d);
    logic [MAX_BITS-1:0] m;
    m = d & ~({MAX_BITS{1'b1}} << char_bits(len));
    if (stick) return ~even;
    return even ? ^m : ~^m;
  endfunction

endpackage

// File: rtl/uart_fe_sync.sv
module uart_fe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '1;
        else        sr <= d;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], d};
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/uart_fe_bitclk.sv
module uart_fe_bitclk #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] span,
  output logic             mid,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            cnt <= '0;
    else if (!run || last) cnt <= '0;
    else                   cnt <= cnt + 1'b1;

  assign last = run && (cnt == span - 1'b1);
  assign mid  = run && (cnt == (span >> 1));

  // R3: the interval counter never runs past the current interval
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < span));
endmodule

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
  import uart_fe_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          len_in,
  input  logic                lstop_in,
  input  logic                par_en_in,
  input  logic                even_in,
  input  logic                stick_in,
  input  logic                brk_in,
  input  logic [DIV_W-1:0]    div_in,
  input  logic [MAX_BITS-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic                txd
);
  localparam int CNT_W = DIV_W + 2;

  tx_state_t           st;
  logic [1:0]          len_q;
  logic                lstop_q, par_en_q, even_q, stick_q, par_q;
  logic [CNT_W-1:0]    period_q, span;
  logic [MAX_BITS-1:0] sh;
  logic [2:0]          idx;
  logic                mid, last, line;

  assign tx_ready = (st == T_IDLE);

  always_comb begin
    span = period_q;
    if (st == T_STOP && lstop_q)
      span = (len_q == 2'd0) ? period_q + (period_q >> 1) : period_q << 1;
  end

  uart_fe_bitclk #(.CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(st != T_IDLE), .span(span),
    .mid(mid), .last(last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= T_IDLE; len_q <= '0; lstop_q <= 1'b0; par_en_q <= 1'b0;
      even_q <= 1'b0; stick_q <= 1'b0; par_q <= 1'b0;
      period_q <= '0; sh <= '0; idx <= '0;
    end else begin
      case (st)
        T_IDLE: if (tx_valid) begin
          st       <= T_START;
          len_q    <= len_in;
          lstop_q  <= lstop_in;
          par_en_q <= par_en_in;
          even_q   <= even_in;
          stick_q  <= stick_in;
          par_q    <= par_bit(len_in, even_in, stick_in, tx_data);
          period_q <= {2'b00, div_in} + CNT_W'(2);
          sh       <= tx_data;
          idx      <= '0;
        end
        T_START: if (last) st <= T_DATA;
        T_DATA: if (last) begin
          sh <= sh >> 1;
          if ({1'b0, idx} == char_bits(len_q) - LEN_W'(1))
            st <= par_en_q ? T_PAR : T_STOP;
          else
            idx <= idx + 3'd1;
        end
        T_PAR:  if (last) st <= T_STOP;
        T_STOP: if (last) st <= T_IDLE;
        default: st <= T_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      T_START: line = 1'b0;
      T_DATA:  line = sh[0];
      T_PAR:   line = par_q;
      default: line = 1'b1;
    endcase
  end

  assign txd = line & ~brk_in;

  // R2: acceptance drops ready for the frame
  a_r2_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  // R2: start bit follows acceptance
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !txd);
  // R8: captured format stays put while a frame runs
  a_r8_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && $past(!tx_ready)) |->
      $stable({len_q, lstop_q, par_en_q, even_q, stick_q, period_q}));
  // R3: the line does not change inside a bit up to its middle
  a_r3_bit_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (mid && !brk_in && !$past(brk_in)) |-> $stable(txd));
endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
  import uart_fe_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          len_in,
  input  logic                par_en_in,
  input  logic                even_in,
  input  logic                stick_in,
  input  logic [DIV_W-1:0]    div_in,
  input  logic                rxd_s,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_valid,
  output logic                rx_perr,
  output logic                rx_ferr,
  output logic                rx_brk
);
  localparam int CNT_W = DIV_W + 2;

  rx_state_t           st;
  logic [1:0]          len_q;
  logic                par_en_q, even_q, stick_q, zero_q, perr_q;
  logic [CNT_W-1:0]    period_q;
  logic [MAX_BITS-1:0] dat;
  logic [2:0]          idx;
  logic                mid, last, run;

  assign run = (st == R_START) || (st == R_DATA) || (st == R_PAR) || (st == R_STOP);

  uart_fe_bitclk #(.CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .span(period_q),
    .mid(mid), .last(last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= R_IDLE; len_q <= '0; par_en_q <= 1'b0; even_q <= 1'b0; stick_q <= 1'b0;
      zero_q <= 1'b0; perr_q <= 1'b0; period_q <= '0; dat <= '0; idx <= '0;
      rx_data <= '0; rx_valid <= 1'b0; rx_perr <= 1'b0; rx_ferr <= 1'b0; rx_brk <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        R_IDLE: if (!rxd_s) begin
          st       <= R_START;
          len_q    <= len_in;
          par_en_q <= par_en_in;
          even_q   <= even_in;
          stick_q  <= stick_in;
          period_q <= {2'b00, div_in} + CNT_W'(2);
          dat      <= '0;
          idx      <= '0;
          zero_q   <= 1'b1;
          perr_q   <= 1'b0;
        end
        R_START: begin
          if (mid && rxd_s) st <= R_IDLE;
          else if (last)    st <= R_DATA;
        end
        R_DATA: begin
          if (mid) begin
            dat[idx] <= rxd_s;
            zero_q   <= zero_q & ~rxd_s;
          end
          if (last) begin
            if ({1'b0, idx} == char_bits(len_q) - LEN_W'(1))
              st <= par_en_q ? R_PAR : R_STOP;
            else
              idx <= idx + 3'd1;
          end
        end
        R_PAR: begin
          if (mid) begin
            perr_q <= (rxd_s != par_bit(len_q, even_q, stick_q, dat));
            zero_q <= zero_q & ~rxd_s;
          end
          if (last) st <= R_STOP;
        end
        R_STOP: if (mid) begin
          rx_valid <= 1'b1;
          rx_data  <= dat;
          rx_perr  <= perr_q;
          rx_ferr  <= ~rxd_s;
          rx_brk   <= zero_q & ~rxd_s;
          st       <= rxd_s ? R_IDLE : R_WAIT;
        end
        R_WAIT: if (rxd_s) st <= R_IDLE;
        default: st <= R_IDLE;
      endcase
    end
  end

  // R12: strobe lasts one cycle
  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R10: a break is also a framing error with all-zero data
  a_r10_break_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_brk) |-> (rx_ferr && rx_data == '0));
  // R11: after a low stop bit the receiver waits for a high line
  a_r11_hold_after_ferr: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ferr) |-> (st == R_WAIT));
  // R9: a high line never opens a frame
  a_r9_no_start_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == R_IDLE && rxd_s) |=> (st == R_IDLE));
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
  import uart_fe_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [6:0]          line_ctrl,
  input  logic [DIV_W-1:0]    divisor,
  input  logic [MAX_BITS-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic                txd,
  input  logic                rxd,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_valid,
  output logic                rx_perr,
  output logic                rx_ferr,
  output logic                rx_brk
);
  line_cfg_t cfg;
  logic      rxd_s;

  assign cfg = line_ctrl;

  uart_fe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
  );

  uart_fe_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .len_in(cfg.len), .lstop_in(cfg.long_stop), .par_en_in(cfg.par_en),
    .even_in(cfg.even), .stick_in(cfg.stick), .brk_in(cfg.brk),
    .div_in(divisor), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .txd(txd)
  );

  uart_fe_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .len_in(cfg.len), .par_en_in(cfg.par_en), .even_in(cfg.even),
    .stick_in(cfg.stick), .div_in(divisor), .rxd_s(rxd_s),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_brk(rx_brk)
  );
endmodule

// File: tb/uart_frame_engine_test.sv
module uart_frame_engine_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] line_ctrl = 7'd3;
  logic [15:0] divisor = 16'd9;
  logic [7:0] tx_data = 8'd0;
  logic       tx_valid = 1'b0;
  logic       tx_ready, txd;
  logic       rxd = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, rx_perr, rx_ferr, rx_brk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit fr[$];
  logic [10:0] mon_q[$];
  int mon_c[$];

  uart_frame_engine uut (
    .clk(clk), .rst_n(rst_n), .line_ctrl(line_ctrl), .divisor(divisor),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_brk(rx_brk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (rst_n && rx_valid) begin
      mon_q.push_back({rx_brk, rx_ferr, rx_perr, rx_data});
      mon_c.push_back(cyc);
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural expected line waveform, one entry per clock
  task automatic build(input logic [6:0] c, input int div, input logic [7:0] d, input bit flip);
    int p, nb, ones, s;
    bit pb;
    p = div + 2;
    nb = 5 + int'(c[1:0]);
    fr.delete();
    repeat (p) fr.push_back(1'b0);
    ones = 0;
    for (int i = 0; i < nb; i++) begin
      repeat (p) fr.push_back(d[i]);
      ones += int'(d[i]);
    end
    if (c[3]) begin
      pb = c[5] ? !c[4] : (c[4] ? ones[0] : !ones[0]);
      if (flip) pb = !pb;
      repeat (p) fr.push_back(pb);
    end
    s = c[2] ? ((nb == 5) ? p + p / 2 : 2 * p) : p;
    repeat (s) fr.push_back(1'b1);
  endtask

  task automatic tx_send(input logic [6:0] c, input int div, input logic [7:0] d,
                         input string tag, input int chg_at, input logic [6:0] c_new,
                         input int div_new, input int b0, input int b1);
    logic [6:0] cur;
    bit e;
    @(negedge clk);
    line_ctrl = c; divisor = 16'(div); tx_data = d; tx_valid = 1'b1;
    #1;
    chk(tx_ready === 1'b1, "R2", int'(tx_ready), 1);
    build(c, div, d, 1'b0);
    @(posedge clk);
    cur = c;
    for (int i = 0; i < fr.size(); i++) begin
      @(negedge clk);
      if (i == 0) begin tx_valid = 1'b0; tx_data = ~d; end
      if (i == chg_at) begin cur = c_new; divisor = 16'(div_new); end
      line_ctrl = {(i >= b0 && i < b1), cur[5:0]};
      #1;
      e = (i >= b0 && i < b1) ? 1'b0 : fr[i];
      chk(txd === e, tag, int'(txd), int'(e));
      chk(tx_ready === 1'b0, "R2", int'(tx_ready), 0);
    end
    @(negedge clk);
    line_ctrl = {1'b0, cur[5:0]};
    #1;
    chk(tx_ready === 1'b1 && txd === 1'b1, "R6", int'({tx_ready, txd}), 3);
  endtask

  task automatic rx_check(input string tag, input logic [10:0] exp, input bit chk_perr,
                          input int lo, input int hi);
    chk(mon_q.size() == 1, "R12", mon_q.size(), 1);
    if (mon_q.size() >= 1) begin
      chk(mon_q[0][7:0] == exp[7:0], tag, int'(mon_q[0][7:0]), int'(exp[7:0]));
      chk(mon_q[0][10:9] == exp[10:9], "R10", int'(mon_q[0][10:9]), int'(exp[10:9]));
      if (chk_perr) chk(mon_q[0][8] == exp[8], tag, int'(mon_q[0][8]), int'(exp[8]));
      chk(mon_c[0] >= lo && mon_c[0] <= hi, "R12", mon_c[0], lo);
    end
    mon_q.delete(); mon_c.delete();
  endtask

  task automatic rx_frame(input logic [6:0] c, input int div, input logic [7:0] d,
                          input bit flip, input bit stop_low, input bit exp_perr, input string tag);
    int p, nb, k, n;
    logic [7:0] m;
    p = div + 2; nb = 5 + int'(c[1:0]); k = 1 + nb + int'(c[3]);
    m = 8'((1 << nb) - 1) & d;
    @(negedge clk);
    line_ctrl = c; divisor = 16'(div);
    build(c, div, d, flip);
    mon_q.delete(); mon_c.delete();
    @(negedge clk);
    n = cyc;
    for (int i = 0; i < k * p; i++) begin rxd = fr[i]; @(negedge clk); end
    rxd = !stop_low;
    repeat (p) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * p) @(negedge clk);
    rx_check(tag, {1'b0, stop_low, exp_perr, m}, 1'b1, n + k * p + p / 2 + 1, n + k * p + p + 3);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(txd === 1'b1 && tx_ready === 1'b1 && rx_valid === 1'b0, "R2", int'({txd, tx_ready, rx_valid}), 6);

    // transmit formats
    tx_send(7'd3,  9,  8'hA5, "R1", -1, 7'd0, 9, -1, -1);   // 8N1, P=11 (R3)
    tx_send(7'd26, 14, 8'h53, "R4", -1, 7'd0, 14, -1, -1);  // 7 bits even
    tx_send(7'd13, 12, 8'h2C, "R4", -1, 7'd0, 12, -1, -1);  // 6 bits odd, 2 stop (R6)
    tx_send(7'd4,  12, 8'h16, "R6", -1, 7'd0, 12, -1, -1);  // 5 bits, 1.5 stop
    tx_send(7'd59, 9,  8'h01, "R5", -1, 7'd0, 9, -1, -1);   // stick, parity 0
    tx_send(7'd43, 9,  8'h03, "R5", -1, 7'd0, 9, -1, -1);   // stick, parity 1
    tx_send(7'd3,  9,  8'hC3, "R8", 5, 7'd28, 11, -1, -1);  // change mid-frame
    tx_send(7'd28, 11, 8'h1D, "R1", -1, 7'd0, 11, -1, -1);  // new format applies
    tx_send(7'd3,  10, 8'hFF, "R7", -1, 7'd0, 10, 20, 40);  // break inside frame

    // break while idle (R7)
    @(negedge clk); line_ctrl = 7'h43; #1;
    for (int i = 0; i < 5; i++) begin
      chk(txd === 1'b0, "R7", int'(txd), 0);
      @(negedge clk); #1;
    end
    line_ctrl = 7'd3; #1;
    chk(txd === 1'b1, "R7", int'(txd), 1);

    // receive
    rx_frame(7'd3,  9,  8'h96, 1'b0, 1'b0, 1'b0, "R1");   // 8N1 (R9)
    rx_frame(7'd26, 14, 8'h35, 1'b1, 1'b0, 1'b1, "R4");   // bad even parity
    rx_frame(7'd26, 14, 8'h35, 1'b0, 1'b0, 1'b0, "R4");
    rx_frame(7'd41, 12, 8'h2A, 1'b0, 1'b0, 1'b0, "R5");   // 6 bits stick odd
    rx_frame(7'd41, 12, 8'h2A, 1'b1, 1'b0, 1'b1, "R5");
    rx_frame(7'd2,  9,  8'h55, 1'b0, 1'b1, 1'b0, "R10");  // framing error

    // false start (R9)
    @(negedge clk); line_ctrl = 7'd3; divisor = 16'd9;
    mon_q.delete(); mon_c.delete();
    rxd = 1'b0; repeat (3) @(negedge clk);
    rxd = 1'b1; repeat (40) @(negedge clk);
    chk(mon_q.size() == 0, "R9", mon_q.size(), 0);

    // long break (R10, R11)
    mon_q.delete(); mon_c.delete();
    rxd = 1'b0; repeat (400) @(negedge clk);
    rxd = 1'b1; repeat (30) @(negedge clk);
    chk(mon_q.size() == 1, "R11", mon_q.size(), 1);
    if (mon_q.size() >= 1) begin
      chk(mon_q[0][10:9] == 2'b11, "R10", int'(mon_q[0][10:9]), 3);
      chk(mon_q[0][7:0] == 8'h00, "R10", int'(mon_q[0][7:0]), 0);
    end
    mon_q.delete(); mon_c.delete();
    rx_frame(7'd0, 9, 8'h13, 1'b0, 1'b0, 1'b0, "R11");   // recovery, 5 bits

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule